// File: doc/BRIEF.md
# SR-IOV Capability Register Block

This block holds the configuration-space registers of a single-root I/O virtualization capability inside a physical function. Software reaches it through a dword-wide configuration port: a write strobe, a dword address, four byte enables and write data. Reads are combinational on the address. The capability occupies a window of sixteen dwords whose base is a parameter. Each writable field has a fixed write mask, and every byte lane whose enable is set merges as (old & ~mask) | (new & mask).

Besides storing the fields, the block decides when the virtual functions come up and when they go down. A write to the control word that sets the enable bit brings them up only when the requested count is at least one and no larger than the total the function offers. A write that clears the enable bit takes them all down. The active state and count appear on output ports, together with one-cycle pulses on each transition. Each of the six VF BAR dwords takes a write mask derived from its configured size. A 64-bit memory BAR uses the next dword as its upper half.

Top module: `sriov_cap_regs`

## Requirements
- R1: Dword addresses CAP_BASE_DW to CAP_BASE_DW+15 hit the capability, and the base is aligned to 16 dwords. Outside that window cfg_hit is 0, cfg_rdata is 0 and writes change nothing. Dwords 0, 1 and 15 of the window read as 0.
- R2: The control word is dword 2, bits [15:0]. Only bit 0 (VF enable), bit 3 (VF memory space enable) and bit 4 (ARI capable hierarchy) are writable. Every other bit of dword 2 reads 0.
- R3: A write changes only the byte lanes whose cfg_be bit is set. cfg_be[n] covers bits [8n+7:8n].
- R4: The requested VF count is dword 4, bits [15:0]. It is fully writable, resets to 0 and bits [31:16] read 0.
- R5: These fields are read-only parameter values: dword 3 holds initial VFs in [15:0] and total VFs in [31:16]; dword 5 holds the VF offset in [15:0] and the VF stride in [31:16]; dword 6 holds the VF device ID in [31:16]; dword 7 holds the supported page sizes, 0x0553 | PGSZ_OPT, in [15:0].
- R6: The system page size is dword 8, bits [15:0], and resets to 0x0001. Its write mask is 0x0553, or the supported page sizes when PGSZ_OPT is nonzero.
- R7: The activation rule applies to a write to dword 2 with cfg_be[0] set and wdata bit 0 equal to 1, made while VFs are inactive. VFs become active in the next cycle when 1 <= requested count <= total VFs. num_vfs_active then takes the requested count and vf_up_pulse is high for one cycle. In any other case VFs stay inactive and no pulse appears.
- R8: A write to dword 2 with cfg_be[0] set and wdata bit 0 equal to 0, made while VFs are active, deactivates them in the next cycle. num_vfs_active becomes 0 and vf_down_pulse is high for one cycle. While VFs are active, the following have no effect on vf_active or num_vfs_active: writes that keep bit 0 set, writes to dword 2 without cfg_be[0], and changes to the requested count.
- R9: VF BARs 0 to 5 are dwords 9 to 14. The write mask of each is ~(2^log2size - 1). Its type bits are read-only and hold the configured type: bits [3:0] for memory, bits [1:0] for I/O (type bit 0 = 1). A BAR with log2size 0 is unimplemented and reads 0.
- R10: A BAR whose type has bit 0 = 0 and bits [2:1] = 2'b10 is a 64-bit memory BAR. The following dword is its upper half. That dword resets to 0 and takes bits [63:32] of the 64-bit mask ~(2^log2size - 1).
- R11: Reset leaves the following state: control word 0, VFs inactive with count 0, requested count 0, system page size 0x0001, and each BAR dword at its type value, or 0 for upper halves and unimplemented BARs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Dword address of the access |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_hit | output | 1 | Address falls inside the capability window |
| cfg_rdata | output | 32 | Read data for cfg_addr, 0 on a miss |
| vf_active | output | 1 | Virtual functions are active |
| num_vfs_active | output | 16 | Number of active virtual functions |
| vf_up_pulse | output | 1 | One-cycle pulse on activation |
| vf_down_pulse | output | 1 | One-cycle pulse on deactivation |

## Verification
The bench requests nine VFs against a total of eight, then exactly eight, then zero. A design with an off-by-one range test would bring up nine functions or refuse eight. A design that accepts a zero count would report active with no functions. With VFs active, the bench rewrites the requested count, writes the enable bit again and writes dword 2 without the low byte lane. A design that follows the live count or misreads the byte lane would change or drop the active set. The bench also writes all ones to every BAR, including the upper half of the 64-bit pair. A design that used one mask for both dwords, or allowed writes to the type bits, would read back wrong bases and corrupt the type.

// File: rtl/sriov_cap_pkg.sv
package sriov_cap_pkg;

  localparam int CAP_DWORDS = 16;
  localparam int NUM_BARS   = 6;

  localparam int DW_CTRL  = 2;
  localparam int DW_VFCNT = 3;
  localparam int DW_NUMVF = 4;
  localparam int DW_ROUTE = 5;
  localparam int DW_DEVID = 6;
  localparam int DW_SUPPG = 7;
  localparam int DW_SYSPG = 8;
  localparam int DW_BAR0  = 9;

  localparam logic [31:0] CTRL_WMASK = 32'h0000_0019;
  localparam logic [15:0] PGSZ_MIN   = 16'h0553;

  function automatic logic bar_is64(input logic [3:0] t);
    return (t[0] == 1'b0) && (t[2:1] == 2'b10);
  endfunction

  // A dword is an upper half when the previous one is a 64-bit low half.
  function automatic logic [NUM_BARS-1:0] bar_upper_flags(
    input logic [NUM_BARS*4-1:0] types);
    logic [NUM_BARS-1:0] f;
    f = '0;
    for (int i = 1; i < NUM_BARS; i++) begin
      if (!f[i-1] && bar_is64(types[(i-1)*4 +: 4])) f[i] = 1'b1;
    end
    return f;
  endfunction

  function automatic logic [31:0] bar_wmask(
    input logic [NUM_BARS*4-1:0] types,
    input logic [NUM_BARS*6-1:0] log2s,
    input int                    idx);
    logic [NUM_BARS-1:0] up;
    logic [5:0]          sz;
    logic [63:0]         m;
    logic [31:0]         lo;
    up = bar_upper_flags(types);
    if (idx > 0 && up[idx]) begin
      sz = log2s[(idx-1)*6 +: 6];
      m  = ~((64'd1 << sz) - 64'd1);
      return m[63:32];
    end
    sz = log2s[idx*6 +: 6];
    if (sz == 6'd0) return 32'h0;
    m  = ~((64'd1 << sz) - 64'd1);
    lo = m[31:0];
    if (types[idx*4]) lo = lo & ~32'h3;
    else              lo = lo & ~32'hF;
    return lo;
  endfunction

  function automatic logic [31:0] bar_rstval(
    input logic [NUM_BARS*4-1:0] types,
    input logic [NUM_BARS*6-1:0] log2s,
    input int                    idx);
    logic [NUM_BARS-1:0] up;
    up = bar_upper_flags(types);
    if (up[idx]) return 32'h0;
    if (log2s[idx*6 +: 6] == 6'd0) return 32'h0;
    if (types[idx*4]) return {30'h0, types[idx*4 +: 2]};
    return {28'h0, types[idx*4 +: 4]};
  endfunction

endpackage

// File: rtl/sriov_masked_reg.sv
module sriov_masked_reg #(
  parameter logic [31:0] WMASK   = 32'h0,
  parameter logic [31:0] RST_VAL = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] q
);

  logic [31:0] q_r;
  logic [31:0] q_d;

  always_comb begin
    q_d = q_r;
    for (int l = 0; l < 4; l++) begin
      if (be[l]) begin
        q_d[l*8 +: 8] = (q_r[l*8 +: 8] & ~WMASK[l*8 +: 8]) |
                        (wdata[l*8 +: 8] & WMASK[l*8 +: 8]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= RST_VAL;
    end else if (wr_en) begin
      q_r <= q_d;
    end
  end

  assign q = q_r;

endmodule

// File: rtl/sriov_vf_enable_ctl.sv
module sriov_vf_enable_ctl #(
  parameter logic [15:0] TOTAL_VFS = 16'd8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_wr,
  input  logic        vfe_req,
  input  logic [15:0] num_vfs,
  output logic        active,
  output logic [15:0] count,
  output logic        up_pulse,
  output logic        down_pulse
);

  logic        act_q, act_d;
  logic [15:0] cnt_q, cnt_d;
  logic        up_q, up_d;
  logic        dn_q, dn_d;
  logic        req_ok;

  assign req_ok = (num_vfs != 16'd0) && (num_vfs <= TOTAL_VFS);

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    up_d  = 1'b0;
    dn_d  = 1'b0;
    if (!act_q && vfe_req && req_ok) begin
      act_d = 1'b1;
      cnt_d = num_vfs;
      up_d  = 1'b1;
    end else if (act_q && !vfe_req) begin
      act_d = 1'b0;
      cnt_d = 16'd0;
      dn_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= 16'd0;
    end else if (ctrl_wr) begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= ctrl_wr & up_d;
      dn_q <= ctrl_wr & dn_d;
    end
  end

  assign active     = act_q;
  assign count      = cnt_q;
  assign up_pulse   = up_q;
  assign down_pulse = dn_q;

endmodule

// File: rtl/sriov_cap_regs.sv
module sriov_cap_regs
  import sriov_cap_pkg::*;
#(
  parameter int                   ADDR_W      = 10,
  parameter logic [ADDR_W-1:0]    CAP_BASE_DW = 10'h040,
  parameter logic [15:0]          INITIAL_VFS = 16'd8,
  parameter logic [15:0]          TOTAL_VFS   = 16'd8,
  parameter logic [15:0]          VF_OFFSET   = 16'd1,
  parameter logic [15:0]          VF_STRIDE   = 16'd1,
  parameter logic [15:0]          VF_DEVID    = 16'h10CA,
  parameter logic [15:0]          PGSZ_OPT    = 16'h0000,
  parameter logic [NUM_BARS*4-1:0] BAR_TYPE   = {4'h0, 4'h0, 4'h1, 4'h0, 4'h0, 4'hC},
  parameter logic [NUM_BARS*6-1:0] BAR_LOG2   = {6'd0, 6'd0, 6'd5, 6'd12, 6'd0, 6'd20}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic              cfg_hit,
  output logic [31:0]       cfg_rdata,
  output logic              vf_active,
  output logic [15:0]       num_vfs_active,
  output logic              vf_up_pulse,
  output logic              vf_down_pulse
);

  localparam int          IDX_W     = $clog2(CAP_DWORDS);
  localparam logic [15:0] SUP_PGSZ  = PGSZ_MIN | PGSZ_OPT;
  localparam logic [15:0] SYS_WMASK = (PGSZ_OPT != 16'h0) ? SUP_PGSZ : PGSZ_MIN;
  localparam logic [ADDR_W-IDX_W-1:0] BASE_TAG = CAP_BASE_DW[ADDR_W-1:IDX_W];

  logic [IDX_W-1:0]      dw_idx;
  logic [CAP_DWORDS-1:0] wr_sel;
  logic [31:0]           ctrl_q;
  logic [31:0]           numvf_q;
  logic [31:0]           syspg_q;
  logic [31:0]           bar_q [NUM_BARS];
  logic [31:0]           words [CAP_DWORDS];

  // Window decode
  assign cfg_hit = (cfg_addr[ADDR_W-1:IDX_W] == BASE_TAG);
  assign dw_idx  = cfg_addr[IDX_W-1:0];

  always_comb begin
    for (int i = 0; i < CAP_DWORDS; i++) begin
      wr_sel[i] = cfg_wr && cfg_hit && (dw_idx == IDX_W'(i));
    end
  end

  // Writable registers
  sriov_masked_reg #(.WMASK(CTRL_WMASK), .RST_VAL(32'h0)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_sel[DW_CTRL]), .be(cfg_be),
    .wdata(cfg_wdata), .q(ctrl_q));

  sriov_masked_reg #(.WMASK(32'h0000_FFFF), .RST_VAL(32'h0)) u_numvf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_sel[DW_NUMVF]), .be(cfg_be),
    .wdata(cfg_wdata), .q(numvf_q));

  sriov_masked_reg #(.WMASK({16'h0, SYS_WMASK}), .RST_VAL(32'h0000_0001)) u_syspg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_sel[DW_SYSPG]), .be(cfg_be),
    .wdata(cfg_wdata), .q(syspg_q));

  for (genvar b = 0; b < NUM_BARS; b++) begin : g_bar
    localparam logic [31:0] BMASK = bar_wmask(BAR_TYPE, BAR_LOG2, b);
    localparam logic [31:0] BRST  = bar_rstval(BAR_TYPE, BAR_LOG2, b);
    sriov_masked_reg #(.WMASK(BMASK), .RST_VAL(BRST)) u_bar (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_sel[DW_BAR0+b]), .be(cfg_be),
      .wdata(cfg_wdata), .q(bar_q[b]));
  end

  // Enable tracking
  sriov_vf_enable_ctl #(.TOTAL_VFS(TOTAL_VFS)) u_en (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(wr_sel[DW_CTRL] && cfg_be[0]),
    .vfe_req(cfg_wdata[0]),
    .num_vfs(numvf_q[15:0]),
    .active(vf_active),
    .count(num_vfs_active),
    .up_pulse(vf_up_pulse),
    .down_pulse(vf_down_pulse));

  // Read mux
  always_comb begin
    for (int i = 0; i < CAP_DWORDS; i++) words[i] = 32'h0;
    words[DW_CTRL]  = ctrl_q;
    words[DW_VFCNT] = {TOTAL_VFS, INITIAL_VFS};
    words[DW_NUMVF] = numvf_q;
    words[DW_ROUTE] = {VF_STRIDE, VF_OFFSET};
    words[DW_DEVID] = {VF_DEVID, 16'h0};
    words[DW_SUPPG] = {16'h0, SUP_PGSZ};
    words[DW_SYSPG] = syspg_q;
    for (int b = 0; b < NUM_BARS; b++) words[DW_BAR0+b] = bar_q[b];
  end

  assign cfg_rdata = cfg_hit ? words[dw_idx] : 32'h0;

endmodule

// File: rtl/sriov_cap_regs_chk.sv
module sriov_cap_regs_chk #(
  parameter int                ADDR_W      = 10,
  parameter logic [ADDR_W-1:0] CAP_BASE_DW = 10'h040,
  parameter logic [15:0]       TOTAL_VFS   = 16'd8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic              cfg_hit,
  input logic [31:0]       cfg_rdata,
  input logic              vf_active,
  input logic [15:0]       num_vfs_active,
  input logic              vf_up_pulse,
  input logic              vf_down_pulse
);

  logic out_win;
  logic at_ctrl;

  assign out_win = (int'(cfg_addr) < int'(CAP_BASE_DW)) ||
                   (int'(cfg_addr) >= int'(CAP_BASE_DW) + sriov_cap_pkg::CAP_DWORDS);
  assign at_ctrl = (int'(cfg_addr) == int'(CAP_BASE_DW) + sriov_cap_pkg::DW_CTRL);

  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_win |-> (!cfg_hit && cfg_rdata == 32'h0)); // R1

  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    at_ctrl |-> ((cfg_rdata & ~sriov_cap_pkg::CTRL_WMASK) == 32'h0)); // R2

  AST_UP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    vf_up_pulse |-> (vf_active && num_vfs_active != 16'd0 &&
                     num_vfs_active <= TOTAL_VFS)); // R7

  AST_UP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    vf_up_pulse |=> !vf_up_pulse); // R7

  AST_DOWN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    vf_down_pulse |-> (!vf_active && num_vfs_active == 16'd0)); // R8

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !vf_active |-> (num_vfs_active == 16'd0)); // R8

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vf_active && $past(vf_active)) |-> $stable(num_vfs_active)); // R8

  AST_NO_DUAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(vf_up_pulse && vf_down_pulse)); // R8

endmodule

bind sriov_cap_regs sriov_cap_regs_chk #(
  .ADDR_W(ADDR_W), .CAP_BASE_DW(CAP_BASE_DW), .TOTAL_VFS(TOTAL_VFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_hit(cfg_hit),
  .cfg_rdata(cfg_rdata), .vf_active(vf_active), .num_vfs_active(num_vfs_active),
  .vf_up_pulse(vf_up_pulse), .vf_down_pulse(vf_down_pulse)
);

// File: tb/sriov_cap_regs_tb_top.sv
`timescale 1ns/1ps
module sriov_cap_regs_tb_top;

  localparam int ADDR_W = 10;
  localparam int BASE   = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_wr = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [3:0]        cfg_be = '0;
  logic [31:0]       cfg_wdata = '0;
  logic              cfg_hit;
  logic [31:0]       cfg_rdata;
  logic              vf_active;
  logic [15:0]       num_vfs_active;
  logic              vf_up_pulse;
  logic              vf_down_pulse;

  int  n_checks = 0;
  int  n_err    = 0;
  bit  done     = 1'b0;

  always #2 clk = ~clk;

  sriov_cap_regs dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_hit(cfg_hit),
    .cfg_rdata(cfg_rdata), .vf_active(vf_active),
    .num_vfs_active(num_vfs_active), .vf_up_pulse(vf_up_pulse),
    .vf_down_pulse(vf_down_pulse));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_abs(input int a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_addr  = ADDR_W'(a);
    cfg_be    = be;
    cfg_wdata = d;
    cfg_wr    = 1'b1;
    @(negedge clk);
    cfg_wr    = 1'b0;
  endtask

  task automatic wr(input int dw, input logic [3:0] be, input logic [31:0] d);
    wr_abs(BASE + dw, be, d);
  endtask

  task automatic rd_abs(input string req, input int a, input logic hit,
                        input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = ADDR_W'(a);
    #1;
    check(req, cfg_rdata, exp);
    check(req, {31'h0, cfg_hit}, {31'h0, hit});
  endtask

  task automatic rd(input string req, input int dw, input logic [31:0] exp);
    rd_abs(req, BASE + dw, 1'b1, exp);
  endtask

  task automatic check_vf(input string req, input logic act, input logic [15:0] cnt,
                          input logic up, input logic dn);
    check(req, {31'h0, vf_active}, {31'h0, act});
    check(req, {16'h0, num_vfs_active}, {16'h0, cnt});
    check(req, {30'h0, vf_up_pulse, vf_down_pulse}, {30'h0, up, dn});
  endtask

  task automatic t_reset_state(input string req);
    rd(req, 2, 32'h0);
    rd(req, 4, 32'h0);
    rd(req, 8, 32'h0000_0001);
    rd(req, 9, 32'h0000_000C);
    rd(req, 10, 32'h0);
    rd(req, 11, 32'h0);
    rd(req, 12, 32'h0000_0001);
    rd(req, 13, 32'h0);
    rd(req, 14, 32'h0);
    check_vf(req, 1'b0, 16'd0, 1'b0, 1'b0);
  endtask

  task automatic t_window();
    rd_abs("R1 below window", BASE - 1, 1'b0, 32'h0);
    rd_abs("R1 above window", BASE + 16, 1'b0, 32'h0);
    wr_abs(BASE + 16 + 4, 4'hF, 32'hFFFF_FFFF);
    rd("R1 outside write ignored", 4, 32'h0);
    rd("R1 dword0 zero", 0, 32'h0);
    rd("R1 dword1 zero", 1, 32'h0);
    rd("R1 dword15 zero", 15, 32'h0);
  endtask

  task automatic t_ctrl();
    wr(2, 4'hF, 32'hFFFF_FFFF);
    check_vf("R7 zero count stays inactive", 1'b0, 16'd0, 1'b0, 1'b0);
    rd("R2 ctrl writable bits", 2, 32'h0000_0019);
    wr(2, 4'hF, 32'h0);
    rd("R2 ctrl cleared", 2, 32'h0);
  endtask

  task automatic t_lanes();
    wr(4, 4'b0001, 32'hFFFF_1234);
    rd("R3 lane0 only", 4, 32'h0000_0034);
    wr(4, 4'b0010, 32'h5555_AB00);
    rd("R3 lane1 only", 4, 32'h0000_AB34);
    wr(4, 4'hF, 32'hFFFF_FFFF);
    rd("R4 numvfs full mask", 4, 32'h0000_FFFF);
    wr(4, 4'b0000, 32'h0);
    rd("R3 no lanes", 4, 32'h0000_FFFF);
    wr(4, 4'hF, 32'h0);
    rd("R4 numvfs cleared", 4, 32'h0);
  endtask

  task automatic t_readonly();
    for (int dw = 3; dw <= 7; dw++) begin
      if (dw != 4) wr(dw, 4'hF, 32'hA5A5_5A5A);
    end
    rd("R5 vf counts", 3, 32'h0008_0008);
    rd("R5 offset stride", 5, 32'h0001_0001);
    rd("R5 device id", 6, 32'h10CA_0000);
    rd("R5 supported pages", 7, 32'h0000_0553);
  endtask

  task automatic t_pgsz();
    wr(8, 4'hF, 32'hFFFF_FFFF);
    rd("R6 sys page mask", 8, 32'h0000_0553);
    wr(8, 4'hF, 32'h0000_0002);
    rd("R6 sys page 8K", 8, 32'h0000_0002);
  endtask

  task automatic t_enable();
    wr(4, 4'b0011, 32'd9);
    wr(2, 4'b0001, 32'h1);
    check_vf("R7 over total rejected", 1'b0, 16'd0, 1'b0, 1'b0);
    wr(2, 4'b0001, 32'h0);
    wr(4, 4'b0011, 32'd8);
    wr(2, 4'b0001, 32'h1);
    check_vf("R7 at total accepted", 1'b1, 16'd8, 1'b1, 1'b0);
    @(negedge clk);
    check_vf("R7 up pulse one cycle", 1'b1, 16'd8, 1'b0, 1'b0);
    wr(4, 4'b0011, 32'd3);
    check_vf("R8 count ignores numvfs change", 1'b1, 16'd8, 1'b0, 1'b0);
    wr(2, 4'b0001, 32'h1);
    check_vf("R8 re-enable no effect", 1'b1, 16'd8, 1'b0, 1'b0);
    wr(2, 4'b0010, 32'h0);
    check_vf("R8 write without lane0 no effect", 1'b1, 16'd8, 1'b0, 1'b0);
    wr(2, 4'b0001, 32'h0);
    check_vf("R8 disable", 1'b0, 16'd0, 1'b0, 1'b1);
    @(negedge clk);
    check_vf("R8 down pulse one cycle", 1'b0, 16'd0, 1'b0, 1'b0);
    wr(2, 4'b0001, 32'h1);
    check_vf("R7 smaller count", 1'b1, 16'd3, 1'b1, 1'b0);
  endtask

  task automatic t_bars();
    for (int b = 0; b < 6; b++) wr(9 + b, 4'hF, 32'hFFFF_FFFF);
    rd("R9 R10 bar0 64-bit low", 9, 32'hFFF0_000C);
    rd("R10 bar1 upper half", 10, 32'hFFFF_FFFF);
    rd("R9 bar2 32-bit mem", 11, 32'hFFFF_F000);
    rd("R9 bar3 io", 12, 32'hFFFF_FFE1);
    rd("R9 bar4 unimplemented", 13, 32'h0);
    rd("R9 bar5 unimplemented", 14, 32'h0);
    wr(9, 4'hF, 32'h0);
    rd("R9 bar0 type kept", 9, 32'h0000_000C);
    wr(12, 4'b0001, 32'h0000_0000);
    rd("R9 bar3 lane0 type kept", 12, 32'hFFFF_FF01);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin : main
    do_reset();
    t_reset_state("R11 reset state");
    t_window();
    t_ctrl();
    t_lanes();
    t_readonly();
    t_pgsz();
    t_enable();
    t_bars();
    wr(4, 4'hF, 32'd5);
    do_reset();
    t_reset_state("R11 reset after use");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule